// File: doc/BRIEF.md
# Extension adapter strobe decoder

This block gives an add-on adapter board its own read and write strobes, taken from the host I/O cycles of the controller. Software loads a match value into a configuration byte. Bits 7:1 of that byte are compared with host address bits 9:3. Every host I/O access that lands in the resulting 8-port window is passed to the adapter. A host read drives the external read strobe, and a host write drives the external write strobe.

The adapter can also take part in DMA. While its DMA acknowledge input is asserted, a host read or write strobe drives the matching external strobe whatever the address is. Two configuration inputs control the decoder. One enables the whole function. The other makes both external strobes active-low. The strobe path is purely combinational. The clock and reset are used only by the embedded checks.

Top module: `xa_decoder`

## Requirements
- R1: The external strobes assert for an access only when host address bits 9:3 equal configuration bits 7:1. Address bits 2:0 do not affect the decision, so one setting covers 8 consecutive ports (value C0H selects ports 300H to 307H).
- R2: Host address bits above bit 9 do not take part in the compare.
- R3: When the mode is enabled and the address is in the window, host read alone asserts the external read strobe, and host write alone asserts the external write strobe.
- R4: When the mode is enabled and DMA acknowledge is high, host read alone asserts the external read strobe and host write alone asserts the external write strobe, for any address.
- R5: With active_low_i = 1, an asserted strobe drives 0 and an idle strobe drives 1. With active_low_i = 0 the levels are reversed.
- R6: With the mode disabled, both strobes stay at their inactive level for every input pattern.
- R7: If host read and host write are high together, neither external strobe asserts, so the two strobes never assert together.
- R8: Configuration bit 0 has no effect on the outputs.
- R9: With no window hit and no DMA acknowledge, both strobes stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| mode_en_i | input | 1 | Enables extension adapter decoding |
| active_low_i | input | 1 | 1 makes both external strobes active-low |
| match_cfg_i | input | 8 | Match byte; bits 7:1 are compared with address bits 9:3 |
| host_addr_i | input | 16 | Host I/O address |
| host_rd_i | input | 1 | Host I/O read strobe, active-high |
| host_wr_i | input | 1 | Host I/O write strobe, active-high |
| dma_ack_i | input | 1 | Adapter DMA acknowledge, active-high |
| ext_rd_o | output | 1 | External read strobe, polarity set by active_low_i |
| ext_wr_o | output | 1 | External write strobe, polarity set by active_low_i |

## Verification
The bench sweeps all 1024 ports of the compared address range. Each port is tried with random upper address bits, under match values C0H, C1H, 00H and FEH. The sweep shows that the hit depends only on bits 9:3. Varying bits 2:0, the upper bits and configuration bit 0 shows that these inputs are ignored. Every sweep is repeated for all four host strobe combinations, both DMA acknowledge levels, both polarities and both mode settings. Together these separate an address hit from a DMA hit, reads from writes, and the conflict case from a normal access, and they show that the inactive level follows the polarity input.

// File: rtl/xa_pkg.sv
package xa_pkg;
  localparam int unsigned XA_CMP_LO = 3;
  localparam int unsigned XA_CMP_HI = 9;
  localparam int unsigned XA_CMP_W  = XA_CMP_HI - XA_CMP_LO + 1;
  localparam int unsigned XA_NSTB   = 2;

  typedef enum logic [0:0] {STB_RD = 1'b0, STB_WR = 1'b1} stb_e;
endpackage

// File: rtl/xa_addr_cmp.sv
module xa_addr_cmp #(
  parameter int unsigned CMP_W = xa_pkg::XA_CMP_W
) (
  input  logic [CMP_W-1:0] addr_field_i,
  input  logic [CMP_W-1:0] match_field_i,
  output logic             hit_o
);
  assign hit_o = (addr_field_i == match_field_i);
endmodule

// File: rtl/xa_strobe_qual.sv
module xa_strobe_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_en_i,
  input  logic hit_i,
  input  logic dma_ack_i,
  input  logic host_rd_i,
  input  logic host_wr_i,
  output logic [xa_pkg::XA_NSTB-1:0] act_o
);
  import xa_pkg::*;

  logic sel;
  logic rd_only, wr_only;

  assign sel     = mode_en_i & (hit_i | dma_ack_i);
  assign rd_only = host_rd_i & ~host_wr_i;
  assign wr_only = host_wr_i & ~host_rd_i;

  always_comb begin
    act_o         = '0;
    act_o[STB_RD] = sel & rd_only;
    act_o[STB_WR] = sel & wr_only;
  end

  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_o[STB_RD] && act_o[STB_WR])); // R7
  AST_CONFLICT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_wr_i) |-> (act_o == '0)); // R7
endmodule

// File: rtl/xa_pol_drive.sv
module xa_pol_drive #(
  parameter int unsigned N = xa_pkg::XA_NSTB
) (
  input  logic         active_low_i,
  input  logic [N-1:0] act_i,
  output logic [N-1:0] pin_o
);
  for (genvar g = 0; g < N; g++) begin : g_pol
    assign pin_o[g] = act_i[g] ^ active_low_i;
  end
endmodule

// File: rtl/xa_decoder.sv
module xa_decoder #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              active_low_i,
  input  logic [7:0]        match_cfg_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic              dma_ack_i,
  output logic              ext_rd_o,
  output logic              ext_wr_o
);
  import xa_pkg::*;

  localparam int unsigned CMP_W = XA_CMP_W;

  logic             hit;
  logic [XA_NSTB-1:0] act;
  logic [XA_NSTB-1:0] pins;
  logic             unused_bits;

  // bits above the window and cfg bit 0 are intentionally ignored
  if (ADDR_W > XA_CMP_HI + 1) begin : g_upper
    assign unused_bits = ^{host_addr_i[ADDR_W-1:XA_CMP_HI+1], host_addr_i[XA_CMP_LO-1:0], match_cfg_i[0]};
  end else begin : g_noupper
    assign unused_bits = ^{host_addr_i[XA_CMP_LO-1:0], match_cfg_i[0]};
  end

  xa_addr_cmp #(.CMP_W(CMP_W)) u_cmp (
    .addr_field_i  (host_addr_i[XA_CMP_HI:XA_CMP_LO]),
    .match_field_i (match_cfg_i[7:1]),
    .hit_o         (hit)
  );

  xa_strobe_qual u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_en_i (mode_en_i),
    .hit_i     (hit),
    .dma_ack_i (dma_ack_i),
    .host_rd_i (host_rd_i),
    .host_wr_i (host_wr_i),
    .act_o     (act)
  );

  xa_pol_drive #(.N(XA_NSTB)) u_pol (
    .active_low_i (active_low_i),
    .act_i        (act),
    .pin_o        (pins)
  );

  assign ext_rd_o = pins[STB_RD];
  assign ext_wr_o = pins[STB_WR];

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |-> (ext_rd_o == active_low_i && ext_wr_o == active_low_i)); // R6
  AST_MISS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[XA_CMP_HI:XA_CMP_LO] != match_cfg_i[7:1] && !dma_ack_i) |-> (act == '0)); // R9
  AST_HIT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && host_addr_i[XA_CMP_HI:XA_CMP_LO] == match_cfg_i[7:1] && host_rd_i && !host_wr_i)
      |-> (ext_rd_o != active_low_i)); // R3
  AST_DMA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && dma_ack_i && host_wr_i && !host_rd_i) |-> (ext_wr_o != active_low_i)); // R4
endmodule

// File: tb/xa_decoder_tb.sv
`timescale 1ns/1ps
module xa_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_en_i = 1'b0;
  logic        active_low_i = 1'b0;
  logic [7:0]  match_cfg_i = 8'h00;
  logic [15:0] host_addr_i = 16'h0000;
  logic        host_rd_i = 1'b0;
  logic        host_wr_i = 1'b0;
  logic        dma_ack_i = 1'b0;
  logic        ext_rd_o, ext_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xa_decoder u_dut (.*);

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h cfg=%h rd=%b wr=%b dma=%b mode=%b pol=%b actual=%b expected=%b",
               req, host_addr_i, match_cfg_i, host_rd_i, host_wr_i, dma_ack_i,
               mode_en_i, active_low_i, act, exp);
    end
  endtask

  function automatic string tag(input logic hit, input logic both);
    if (!mode_en_i) return "R6";
    if (both) return "R7";
    if (dma_ack_i) return "R4";
    if (hit) return "R3";
    return "R9";
  endfunction

  initial begin
    logic [7:0] cfgs [4];
    cfgs[0] = 8'hC0; cfgs[1] = 8'hC1; cfgs[2] = 8'h00; cfgs[3] = 8'hFE;
    // reset state: mode off, polarity high => idle low
    #2;
    chk(ext_rd_o, 1'b0, "R6 reset rd");
    chk(ext_wr_o, 1'b0, "R6 reset wr");
    active_low_i = 1'b1; #1;
    chk(ext_rd_o, 1'b1, "R5 idle rd");
    chk(ext_wr_o, 1'b1, "R5 idle wr");
    @(negedge clk_i); rst_ni = 1'b1;
    // directed: C0H window is 300H..307H (R1)
    mode_en_i = 1'b1; active_low_i = 1'b0; match_cfg_i = 8'hC0; host_rd_i = 1'b1;
    host_addr_i = 16'h0307; #2; chk(ext_rd_o, 1'b1, "R1 307");
    host_addr_i = 16'h0308; #2; chk(ext_rd_o, 1'b0, "R1 308");
    host_addr_i = 16'h02FF; #2; chk(ext_rd_o, 1'b0, "R1 2FF");
    host_addr_i = 16'hF300; #2; chk(ext_rd_o, 1'b1, "R2 F300");
    match_cfg_i = 8'hC1; host_addr_i = 16'h0300; #2; chk(ext_rd_o, 1'b1, "R8 C1");
    host_rd_i = 1'b0;
    // sweep
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 8; s++) begin
          for (int a = 0; a < 1024; a++) begin
            logic hit, both, qrd, qwr, erd, ewr;
            match_cfg_i  = cfgs[c];
            mode_en_i    = m[0];
            active_low_i = m[1];
            host_rd_i    = s[0];
            host_wr_i    = s[1];
            dma_ack_i    = s[2];
            host_addr_i  = {$urandom_range(0, 63), a[9:0]};
            #1;
            hit  = ((a >> 3) & 7'h7F) == (cfgs[c] >> 1);
            both = s[0] & s[1];
            qrd  = m[0] & (hit | s[2]) & s[0] & ~s[1];
            qwr  = m[0] & (hit | s[2]) & s[1] & ~s[0];
            erd  = qrd ^ m[1];
            ewr  = qwr ^ m[1];
            chk(ext_rd_o, erd, tag(hit, both));
            chk(ext_wr_o, ewr, m[1] ? "R5" : tag(hit, both));
            #1;
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #2_000_000;
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule